// File: doc/BRIEF.md
# Write-Protect and Status Register Unit

This unit keeps the status byte of a serial memory device and rules on every write the device is asked to make. It sits between the command decoder and the write engine. The decoder gives it one-cycle strobes for write-enable, write-disable and status-write commands, the data byte of a status write, and a strobe that marks the end of a chip-select frame. The write engine gives it its busy flag. The unit answers with the status byte and with two grants. One grant lets the engine program an array byte. The other lets it start a status write cycle.

Three mechanisms control each grant. The first is a write-enable latch. An enable command only arms it, and the latch is set when the frame closes. A write in the same frame as the enable therefore fails. The latch clears when a write cycle finishes. The second is a hardware lock: a lock bit in the status byte combined with a low level on the protect pin. It freezes the status byte but leaves unprotected array addresses writable. The third is a two-bit block-protect field. It shields the top quarter, the top half or the whole of the array, and every byte address is checked against it.

The lock bit and the block-protect bits model non-volatile storage. They clear only on the power-on reset and keep their value across the soft reset.

Top module: `wpsr_unit`

## Requirements
- R1: After a power-on reset (`por_n` low) the status byte reads 0x00 with `busy` low, and both grants are 0.
- R2: A `cmd_wren` strobe only arms the enable latch. The latch, status bit 1, becomes 1 one cycle after the next `frame_end` strobe. Before that, an array request in the same frame is refused.
- R3: A `cmd_wrdi` strobe clears status bit 1 one cycle later. It also drops an armed enable that has not yet been committed by `frame_end`.
- R4: `arr_grant` is 1 one cycle after an `arr_req` exactly when the enable latch is set and the address is outside the protected range. Only address bits 12 and 11 select the range. With status bits 3:2 = 00 nothing is protected. With 01, addresses 0x1800–0x1FFF are protected. With 10, 0x1000–0x1FFF are protected. With 11, every address is protected.
- R5: A `cmd_wrsr` is accepted only when the enable latch is set and the hardware lock is off. The lock is on when `wp_n` is low and status bit 7 is 1. At the following `frame_end`, `sr_grant` pulses one cycle later. In the same cycle, status bits 7, 3 and 2 take data bits 7, 3 and 2, and the other data bits are ignored. While the lock is on, unprotected array writes are still granted.
- R6: If the lock comes on at any cycle between an accepted `cmd_wrsr` and its `frame_end`, the status write is dropped. In that case there is no `sr_grant` and the status byte is unchanged. After the status byte has been updated, later changes of `wp_n` have no effect on it.
- R7: One cycle after `busy` falls, the enable latch reads 0.
- R8: While `busy` is 1, `cmd_wren`, `cmd_wrdi`, `cmd_wrsr` and `arr_req` have no effect. Status bit 0 equals `busy` in the same cycle.
- R9: Status bits 6:4 always read 0.
- R10: A soft reset (`rst_n` low) clears the enable latch but keeps status bits 7, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, clears everything |
| rst_n | input | 1 | Soft reset, synchronous, active low, keeps non-volatile bits |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| frame_end | input | 1 | Strobe marking the rise of chip select |
| wp_n | input | 1 | Write-protect pin level, low asserts protection |
| busy | input | 1 | Write engine busy flag |
| arr_req | input | 1 | Array byte write request strobe |
| arr_addr | input | ADDR_W | Byte address of the array request |
| status | output | 8 | Status byte |
| arr_grant | output | 1 | Array byte write granted |
| sr_grant | output | 1 | Status write granted, engine starts its cycle |

## Verification
Each grant and each change of the enable latch or the non-volatile bits appears exactly one clock after the edge that samples its strobe. The ready bit is the only result that follows its input, `busy`, in the same cycle. The bench drives every strobe for one cycle starting at a falling edge. It samples at the falling edge that follows the capturing rising edge, so each result is read in its first valid cycle and before the next stimulus. Checks of cancelled or ignored commands read the status byte and the grants in that same cycle.

// File: rtl/wpsr_pkg.sv
// Shared definitions for the write-protect and status register unit.
// Assumes an 8-bit status byte with fixed bit positions.
package wpsr_pkg;
    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_level_e;

    localparam int SR_W     = 8;
    localparam int ST_RDY   = 0;
    localparam int ST_WEL   = 1;
    localparam int ST_BP0   = 2;
    localparam int ST_BP1   = 3;
    localparam int ST_LOCK  = 7;
endpackage

// File: rtl/wpsr_range_chk.sv
// Block-protect range compare. Says whether an address falls inside the
// region selected by the two block-protect bits. Assumes the region is the
// top quarter, the top half or the whole of a power-of-two array, so only
// the two address MSBs matter.
module wpsr_range_chk #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import wpsr_pkg::*;

    localparam int TOP = ADDR_W - 1;

    logic [1:0] msb2;
    assign msb2 = addr[TOP -: 2];

    // Decode protection level into a hit on the two address MSBs.
    always_comb begin
        unique case (bp_level_e'(bp))
            BP_NONE:    hit = 1'b0;
            BP_QUARTER: hit = (msb2 == 2'b11);
            BP_HALF:    hit = msb2[1];
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpsr_wel_latch.sv
// Write-enable latch. An enable command arms the latch and frame end
// commits it. A disable command clears it, and so does completion of a
// write cycle (busy falling). Commands are ignored while busy. Assumes all
// command strobes last one cycle.
module wpsr_wel_latch (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic frame_end,
    input  logic busy,
    output logic wel
);
    logic armed;
    logic busy_q;

    // Track busy, arm on enable, commit at frame end, clear on disable or cycle end.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            wel    <= 1'b0;
            armed  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy_q && !busy) begin
                wel   <= 1'b0;
                armed <= 1'b0;
            end else if (!busy) begin
                if (cmd_wrdi) begin
                    wel   <= 1'b0;
                    armed <= 1'b0;
                end else if (cmd_wren) begin
                    armed <= 1'b1;
                end else if (frame_end) begin
                    if (armed) wel <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end

    p_wel_set_at_frame_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(wel) |-> $past(frame_end));

    p_wel_disable_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (cmd_wrdi && !busy) |=> !wel);

    p_wel_cycle_end_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $fell(busy) |=> !wel);
endmodule

// File: rtl/wpsr_nv_regs.sv
// Non-volatile status bits (lock and block protect) together with the
// staging of a status write. A write is staged when the command arrives
// with the enable latch set and the lock off. It is dropped if the lock comes
// on or the engine is busy before frame end, and it is applied at frame end.
// Only the power-on reset clears the stored bits.
module wpsr_nv_regs (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       cmd_wrsr,
    input  logic [7:0] wr_data,
    input  logic       frame_end,
    input  logic       busy,
    input  logic       wel,
    input  logic       wp_n,
    output logic       lock,
    output logic [1:0] bp,
    output logic       sr_grant
);
    import wpsr_pkg::*;

    logic       hw_lock;
    logic       staged;
    logic [2:0] staged_bits;
    logic       commit;

    assign hw_lock = !wp_n && lock;
    assign commit  = staged && frame_end && !hw_lock && !busy;

    // Stage an accepted status write; drop it on lock, busy or frame end.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            staged      <= 1'b0;
            staged_bits <= '0;
            sr_grant    <= 1'b0;
        end else begin
            sr_grant <= commit;
            if (frame_end || hw_lock || busy) begin
                staged <= 1'b0;
            end else if (cmd_wrsr && wel) begin
                staged      <= 1'b1;
                staged_bits <= {wr_data[ST_LOCK], wr_data[ST_BP1], wr_data[ST_BP0]};
            end
        end
    end

    // Hold the non-volatile bits; only power-on clears them.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lock <= 1'b0;
            bp   <= 2'b00;
        end else if (rst_n && commit) begin
            lock <= staged_bits[2];
            bp   <= staged_bits[1:0];
        end
    end

    p_nv_frozen_by_lock_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!wp_n && lock) |=> $stable({lock, bp}));

    p_sgrant_needs_wel_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sr_grant |-> $past(wel));

    p_sgrant_at_frame_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sr_grant |-> $past(frame_end));
endmodule

// File: rtl/wpsr_unit.sv
// Top of the write-protect and status register unit. It builds the status
// byte from the enable latch, the non-volatile bits and the engine busy flag.
// It grants array byte writes that are enabled and outside the protected
// range. Assumes the decoder supplies one-cycle strobes and the engine
// drives busy for the length of each write cycle.
module wpsr_unit #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              frame_end,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output logic              arr_grant,
    output logic              sr_grant
);
    import wpsr_pkg::*;

    logic       wel;
    logic       lock;
    logic [1:0] bp;
    logic       in_range;

    wpsr_wel_latch u_wel (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cmd_wren  (cmd_wren),
        .cmd_wrdi  (cmd_wrdi),
        .frame_end (frame_end),
        .busy      (busy),
        .wel       (wel)
    );

    wpsr_nv_regs u_nv (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cmd_wrsr  (cmd_wrsr),
        .wr_data   (wrsr_data),
        .frame_end (frame_end),
        .busy      (busy),
        .wel       (wel),
        .wp_n      (wp_n),
        .lock      (lock),
        .bp        (bp),
        .sr_grant  (sr_grant)
    );

    wpsr_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .bp   (bp),
        .addr (arr_addr),
        .hit  (in_range)
    );

    // Assemble the status byte; unused bits read 0.
    always_comb begin
        status          = '0;
        status[ST_RDY]  = busy;
        status[ST_WEL]  = wel;
        status[ST_BP0]  = bp[0];
        status[ST_BP1]  = bp[1];
        status[ST_LOCK] = lock;
    end

    // Grant each array byte that is enabled, idle and outside the protected range.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) arr_grant <= 1'b0;
        else                  arr_grant <= arr_req && wel && !in_range && !busy;
    end

    p_arr_needs_wel_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        arr_grant |-> $past(wel));

    p_arr_full_block_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (arr_req && bp == 2'b11) |=> !arr_grant);

    p_arr_busy_ignored_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (arr_req && busy) |=> !arr_grant);
endmodule

// File: tb/wpsr_unit_tb.sv
module wpsr_unit_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
    logic [7:0]  wrsr_data = 8'h00;
    logic        frame_end = 1'b0, wp_n = 1'b1, busy = 1'b0, arr_req = 1'b0;
    logic [12:0] arr_addr = '0;
    logic [7:0]  status;
    logic        arr_grant, sr_grant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wpsr_unit u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .frame_end(frame_end), .wp_n(wp_n),
        .busy(busy), .arr_req(arr_req), .arr_addr(arr_addr),
        .status(status), .arr_grant(arr_grant), .sr_grant(sr_grant)
    );

    // Vectors: {bp[1:0], expected grant, address[12:0]} for R4.
    localparam logic [15:0] VEC [10] = '{
        {2'b00, 1'b1, 13'h1FFF}, {2'b00, 1'b1, 13'h0000},
        {2'b01, 1'b1, 13'h17FF}, {2'b01, 1'b0, 13'h1800},
        {2'b01, 1'b1, 13'h0000}, {2'b10, 1'b1, 13'h0FFF},
        {2'b10, 1'b0, 13'h1000}, {2'b10, 1'b0, 13'h1FFF},
        {2'b11, 1'b0, 13'h0000}, {2'b11, 1'b0, 13'h0FFF}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wren_frame();
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
        frame_end = 1'b1; tick(); frame_end = 1'b0;
    endtask

    task automatic wrdi_pulse();
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
    endtask

    task automatic wrsr_frame(input logic [7:0] d);
        cmd_wrsr = 1'b1; wrsr_data = d; tick(); cmd_wrsr = 1'b0;
        frame_end = 1'b1; tick(); frame_end = 1'b0;
    endtask

    task automatic engine(input int n);
        busy = 1'b1; repeat (n) tick(); busy = 1'b0; tick();
    endtask

    task automatic write_status(input logic [7:0] d);
        wren_frame(); wrsr_frame(d); engine(3);
    endtask

    task automatic arr_pulse(input logic [12:0] a);
        arr_req = 1'b1; arr_addr = a; tick(); arr_req = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1, R9: power-on state
        check("R1 status after por", status, 8'h00);
        por_n = 1'b1; rst_n = 1'b1; tick();
        check("R1 status idle", status, 8'h00);
        check("R1 grants", {6'b0, arr_grant, sr_grant}, 8'h00);

        // R2: enable takes effect only at frame end
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
        arr_pulse(13'h0010);
        check("R2 same-frame array write refused", {7'b0, arr_grant}, 8'h00);
        check("R2 wel before frame end", status, 8'h00);
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        check("R2 wel after frame end", status, 8'h02);

        // R3: disable clears latch and drops an armed enable
        wrdi_pulse();
        check("R3 wel cleared", status, 8'h00);
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
        wrdi_pulse();
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        check("R3 armed enable dropped", status, 8'h00);

        // R5: status write without enable refused
        wrsr_frame(8'hFF);
        check("R5 no grant without wel", {7'b0, sr_grant}, 8'h00);
        check("R5 status unchanged without wel", status, 8'h00);

        // R5, R9: accepted status write only takes bits 7,3,2
        wren_frame();
        wrsr_frame(8'h73);
        check("R5 sr_grant pulse", {7'b0, sr_grant}, 8'h01);
        check("R5 R9 masked bits", status, 8'h02);
        engine(2);
        check("R7 wel clear after status cycle", status, 8'h00);

        // R4: range table walk
        for (int i = 0; i < 10; i++) begin
            write_status({4'b0, VEC[i][15:14], 2'b00});
            wren_frame();
            arr_pulse(VEC[i][12:0]);
            check($sformatf("R4 vector %0d grant", i), {7'b0, arr_grant}, {7'b0, VEC[i][13]});
            wrdi_pulse();
        end
        write_status(8'h00);
        check("R4 bp cleared", status, 8'h00);

        // R5: lock refuses status write, array stays writable
        write_status(8'h80);
        check("R5 lock bit set", status, 8'h80);
        wp_n = 1'b0;
        wren_frame();
        wrsr_frame(8'h0C);
        check("R5 locked write no grant", {7'b0, sr_grant}, 8'h00);
        check("R5 locked status unchanged", status, 8'h82);
        arr_pulse(13'h0100);
        check("R5 unprotected array under lock", {7'b0, arr_grant}, 8'h01);
        wrdi_pulse();

        // R6: lock arriving mid-frame cancels staged write
        wp_n = 1'b1;
        wren_frame();
        cmd_wrsr = 1'b1; wrsr_data = 8'h84; tick(); cmd_wrsr = 1'b0;
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        check("R6 cancelled no grant", {7'b0, sr_grant}, 8'h00);
        check("R6 cancelled status unchanged", status, 8'h82);
        wrsr_frame(8'h84);
        check("R6 accepted write", status, 8'h86);
        wp_n = 1'b0;
        engine(3);
        check("R6 wp after update no effect", status, 8'h84);
        wp_n = 1'b1;

        // R10: soft reset keeps non-volatile bits, clears wel
        wren_frame();
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        check("R10 soft reset", status, 8'h84);

        // R8, R7: commands ignored while busy, ready bit mirrors busy
        write_status(8'h00);
        wren_frame();
        busy = 1'b1; #1;
        check("R8 ready mirrors busy", status, 8'h03);
        tick();
        wrdi_pulse();
        check("R8 disable ignored while busy", status, 8'h03);
        arr_pulse(13'h0000);
        check("R8 array request ignored while busy", {7'b0, arr_grant}, 8'h00);
        busy = 1'b0; tick();
        check("R7 wel clear after busy falls", status, 8'h00);
        busy = 1'b1; wren_frame(); busy = 1'b0; tick();
        check("R8 enable ignored while busy", status, 8'h00);

        // R1: power-on clears non-volatile bits
        write_status(8'h8C);
        por_n = 1'b0; tick(); por_n = 1'b1; tick();
        check("R1 por clears all", status, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule